// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the array address for a synchronous memory that serves four-beat bursts. A load cycle captures a full external address and presents it at once. Each later advance cycle steps the two lowest address bits to the next beat of the burst, and the bits above them stay fixed. The stepping order is either interleaved, where the low bits are the starting low bits XOR a beat count, or linear, where the low bits are the starting low bits plus the beat count modulo four. A mode pin, meant to be tied to a fixed level, picks the order. Either way the burst wraps inside its aligned group of four.

An active-high suspend input freezes the whole sequencer for as long as it is asserted. A select input is captured with each load. After a load taken while unselected, advance requests do not move the address. The memory array and the data path are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `arr_addr` is zero until the first load.
- R2: On a rising edge with `suspend`=0 and `adv`=0 (a load), `arr_addr` takes the value of `ext_addr` after that edge, and the beat count restarts at 0.
- R3: On a rising edge with `suspend`=0, `adv`=1 and the last load taken with `chip_sel`=1, the beat count rises by one, modulo 4.
- R4: With `ilv_sel`=1 (interleaved), the two low bits of `arr_addr` equal the loaded low bits XOR the beat count. A start of 1 gives 1,0,3,2.
- R5: With `ilv_sel`=0 (linear), the two low bits of `arr_addr` equal the loaded low bits plus the beat count, modulo 4. A start of 1 gives 1,2,3,0.
- R6: The fourth advance after a load returns `arr_addr` to the loaded address. Bits 2 and up of `arr_addr` never change on an advance.
- R7: On an edge with `suspend`=1, `arr_addr` is unchanged whatever the values of `adv` and `ext_addr`. A burst that was frozen this way resumes from the beat where it stopped.
- R8: After a load taken with `chip_sel`=0, advance cycles leave `arr_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspend | input | 1 | 1 freezes the sequencer for this cycle |
| adv | input | 1 | 0 loads `ext_addr`; 1 advances the burst |
| ilv_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| chip_sel | input | 1 | Select state captured with each load |
| ext_addr | input | ADDR_W | External address taken on a load |
| arr_addr | output | ADDR_W | Current array address |

## Verification
The bench builds the block with its default parameters: a 17-bit address and a 2-bit beat count. With these values every start offset from 0 to 3 can be run in both orders, and a full wrap fits in four advances. The loaded addresses have the upper bits set in varied patterns, so a carry from the counter that leaks into bit 2 shows up. Suspend cycles are placed in the middle of bursts, and the stimulus on `adv` and `ext_addr` is changed during them.

// File: rtl/bas_pkg.sv
`timescale 1ns/1ps
package bas_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bas_beat_ctr.sv
`timescale 1ns/1ps
module bas_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3: one step per advance, wrapping modulo the burst length
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  // R2: a clear restarts the beat at zero
  p_count_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/bas_order_map.sv
`timescale 1ns/1ps
module bas_order_map
  import bas_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_lo,
  input  logic [CNT_W-1:0] beat,
  input  burst_order_e     order,
  output logic [CNT_W-1:0] lo_out
);
  logic [CNT_W-1:0] xor_lo, sum_lo;

  genvar b;
  generate
    for (b = 0; b < CNT_W; b++) begin : g_xor
      assign xor_lo[b] = start_lo[b] ^ beat[b];
    end
  endgenerate

  assign sum_lo = start_lo + beat;

  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: lo_out = xor_lo;
      default:        lo_out = sum_lo;
    endcase
  end

  // R4 / R5: beat zero always maps to the starting offset in either order
  always_comb begin
    if (beat == '0) a_beat0_r4: assert (lo_out == start_lo);
  end
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              suspend,
  input  logic              adv,
  input  logic              ilv_sel,
  input  logic              chip_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] arr_addr
);
  localparam int UP_W = ADDR_W - BURST_BITS;

  logic [ADDR_W-1:0]     base_q, base_d;
  logic                  active_q, active_d;
  logic                  load_evt, step_evt;
  logic [BURST_BITS-1:0] beat, lo_bits;
  burst_order_e          order;

  assign load_evt = !suspend && !adv;
  assign step_evt = !suspend && adv && active_q;
  assign order    = burst_order_e'(ilv_sel);

  always_comb begin
    base_d   = base_q;
    active_d = active_q;
    if (load_evt) begin
      base_d   = ext_addr;
      active_d = chip_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      active_q <= 1'b0;
    end else begin
      base_q   <= base_d;
      active_q <= active_d;
    end
  end

  bas_beat_ctr #(.CNT_W(BURST_BITS)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (step_evt),
    .clr  (load_evt),
    .cnt  (beat)
  );

  bas_order_map #(.CNT_W(BURST_BITS)) u_map (
    .start_lo(base_q[BURST_BITS-1:0]),
    .beat    (beat),
    .order   (order),
    .lo_out  (lo_bits)
  );

  assign arr_addr = {base_q[ADDR_W-1:BURST_BITS], lo_bits};

  // R2: a load presents the external address on the next cycle
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && !adv) |=> (arr_addr == $past(ext_addr)));
  // R6: advancing never touches the upper bits
  p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && adv) |=> (arr_addr[ADDR_W-1:BURST_BITS] == $past(arr_addr[ADDR_W-1:BURST_BITS])));
  // R7: a suspended cycle changes nothing (mode is static)
  p_suspend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && $stable(ilv_sel)) |=> $stable(arr_addr));
  // R8: advancing while unselected changes nothing
  p_desel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && adv && !active_q && $stable(ilv_sel)) |=> $stable(arr_addr));
  // UP_W kept positive: at least one upper bit exists
  initial a_width_ok_r6: assert (UP_W > 0);
endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          suspend, adv, ilv_sel, chip_sel;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] arr_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;
  exp_t sb[$];

  // reference model state
  logic [AW-1:0] m_start;
  int            m_cnt;
  bit            m_act;

  always #4 clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .suspend (suspend),
    .adv     (adv),
    .ilv_sel (ilv_sel),
    .chip_sel(chip_sel),
    .ext_addr(ext_addr),
    .arr_addr(arr_addr)
  );

  function automatic logic [AW-1:0] model_addr(bit mode);
    logic [1:0] s, c, lo;
    s  = m_start[1:0];
    c  = 2'(m_cnt);
    lo = mode ? (s ^ c) : 2'(s + c);
    return {m_start[AW-1:2], lo};
  endfunction

  task automatic step(bit s, bit a, bit sel, bit mode, logic [AW-1:0] ext, string tag);
    exp_t e;
    @(negedge clk);
    suspend = s; adv = a; chip_sel = sel; ilv_sel = mode; ext_addr = ext;
    if (!s) begin
      if (!a) begin
        m_start = ext; m_cnt = 0; m_act = sel;
      end else if (m_act) begin
        m_cnt = (m_cnt + 1) % 4;
      end
    end
    @(posedge clk);
    e.addr = model_addr(mode);
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // monitor: compares one expected item per clock, away from both edges
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (arr_addr !== e.addr) begin
        fails++;
        $display("FAIL %s: arr_addr=%h expected=%h", e.tag, arr_addr, e.addr);
      end
    end
  end

  task automatic burst(bit mode, logic [AW-1:0] a, string tag);
    step(0, 0, 1, mode, a, "R2");
    for (int i = 0; i < 3; i++) step(0, 1, 1, mode, ~a, tag);
    step(0, 1, 1, mode, ~a, "R6");
  endtask

  initial begin
    rst_n = 1'b0; suspend = 1'b0; adv = 1'b1; ilv_sel = 1'b1;
    chip_sel = 1'b0; ext_addr = '0;
    m_start = '0; m_cnt = 0; m_act = 1'b0;
    #21;
    checks++;
    if (arr_addr !== '0) begin
      fails++; $display("FAIL R1: arr_addr=%h expected=0", arr_addr);
    end
    @(negedge clk); rst_n = 1'b1;
    // R1: advance after reset with nothing loaded keeps zero
    step(0, 1, 1, 1, 17'h1FFFF, "R1");
    // R4: interleaved, all four start offsets
    burst(1, 17'h12345, "R4");
    burst(1, 17'h0ABC8, "R4");
    burst(1, 17'h1F00E, "R4");
    burst(1, 17'h00FF3, "R4");
    // R5: linear, all four start offsets
    burst(0, 17'h12345, "R5");
    burst(0, 17'h0ABC8, "R5");
    burst(0, 17'h1F00E, "R5");
    burst(0, 17'h1FFFF, "R5");
    // R3: continued advances keep cycling through the group
    step(0, 0, 1, 0, 17'h05556, "R2");
    for (int i = 0; i < 9; i++) step(0, 1, 1, 0, 17'h0, "R3");
    // R7: suspend mid-burst, with load and advance attempts
    step(0, 0, 1, 1, 17'h1A5A5, "R2");
    step(0, 1, 1, 1, 17'h0, "R4");
    step(1, 0, 1, 1, 17'h01234, "R7");
    step(1, 1, 1, 1, 17'h0FFFF, "R7");
    step(1, 0, 0, 1, 17'h00000, "R7");
    step(0, 1, 1, 1, 17'h0, "R7");
    step(0, 1, 1, 1, 17'h0, "R7");
    // R8: load while unselected, then advances have no effect
    step(0, 0, 0, 0, 17'h0C3C2, "R2");
    for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 17'h1FFFF, "R8");
    // R2: back-to-back loads
    step(0, 0, 1, 0, 17'h00001, "R2");
    step(0, 0, 1, 0, 17'h10002, "R2");
    step(0, 0, 1, 1, 17'h0F0F3, "R2");
    step(0, 1, 1, 1, 17'h0, "R4");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule